// File: doc/BRIEF.md
# SPI EEPROM Access Sequencer

This block turns host read and write requests for a serial EEPROM into SPI command frames. The host gives a 16-bit start address, a byte count and a write/read flag, then pulses `req_valid` while the block is idle. The block works through the request in pieces of at most `CHUNK` bytes and advances the device address by the size of each piece. A byte-wide mode-0 shift engine drives the SPI pins and serialises each byte MSB first.

For a write piece, the block first sends a one-byte write-enable frame. It then sends the write frame, made of opcode, address high byte, address low byte and the data. After that it repeats a two-byte status frame until the device reports ready. The status frames are spaced one millisecond apart, and this spacing is derived from `CLK_HZ`. If the device is still busy after `MAX_POLLS` status frames, the request is abandoned and an error flag is raised. For a read piece, the block sends a read frame and discards the first three received bytes. It writes every later received byte to the host buffer through `buf_idx`, `buf_rdata` and `buf_we`. The write data comes in through `buf_wdata`, which the host must provide combinationally for the index shown on `buf_idx`.

Top module: `spi_eeprom_seq`

## Requirements
- R1: Opcodes are 0x06 for write-enable, 0x05 for status read, 0x03 for read and 0x02 for write. A read or write frame sends its opcode first, then the address high byte, then the address low byte.
- R2: A request is split into frames of at most CHUNK data bytes (default 16). The address of each frame is the start address plus the number of bytes already handled. A write frame is 3 + n bytes long and a read frame is 3 + n bytes long.
- R3: Every write piece is preceded by its own one-byte write-enable frame, with chip select raised between it and the write frame.
- R4: After each write frame, two-byte status frames are sent until bit 0 of the second received byte is 0. The number of status frames is the number of busy replies plus one.
- R5: Between the end of a status frame that answered busy and the start of the next status frame there are at least CLK_HZ/1000 clock cycles.
- R6: When MAX_POLLS status frames have all answered busy, the request ends with `done` and `err` set, and no further frame is sent.
- R7: In a read frame, received byte k (counting from 0, with k >= 3) is written to buffer index (bytes already handled + k - 3). `buf_we` pulses once for each byte.
- R8: `done` is a single-cycle pulse when a request completes. `busy` is high from the cycle after acceptance until completion. Chip select is low only while `busy` is high.
- R9: `err` stays high after a timeout until the next accepted request. It is cleared in the cycle after that request is accepted.
- R10: A request of length zero raises `done` in the cycle after acceptance and never lowers chip select.
- R11: After reset: chip select is high, `spi_sclk` is low, and `busy`, `done` and `err` are low.
- R12: The SPI clock idles low and toggles only while chip select is low. MOSI changes on falling edges and MISO is sampled on rising edges, with the MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start pulse, accepted while busy is low |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 16 | Device start address |
| req_len | input | LEN_W | Number of data bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Status-poll timeout flag |
| buf_idx | output | LEN_W | Host buffer index for the current data byte |
| buf_wdata | input | 8 | Host buffer byte at buf_idx (write requests) |
| buf_we | output | 1 | Strobe to store buf_rdata at buf_idx |
| buf_rdata | output | 8 | Byte received from the device |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to the device |
| spi_miso | input | 1 | SPI data from the device |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench attaches a behavioural EEPROM model that logs every frame's opcode, length, address and timing, and that can be told how many status replies to answer busy. Write and read requests are run with lengths below one piece, exactly one piece, and a little over one or two pieces. These lengths separate a correct split and address advance from off-by-one piece boundaries. The busy-reply counts are zero, one, two and beyond the poll limit. These counts separate correct poll termination and poll spacing from early exit, and from missing or late timeout. Read-back of previously written patterns shows that the data lands at the right addresses and buffer indices. Directed cases cover reset, zero length, the one-cycle done pulse and clearing of the error flag.

// File: rtl/spi_eeprom_seq_pkg.sv
// Shared constants and types for the SPI EEPROM sequencer.
// Assumes: 8-bit device opcodes, 16-bit device addressing.
package spi_eeprom_seq_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_STAT  = 8'h05;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam int         HDR_BYTES = 3;   // opcode + two address bytes

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHUNK,
        S_WREN,
        S_GAP,
        S_WRITE,
        S_POLL,
        S_WAIT,
        S_READ,
        S_NEXT
    } seq_state_t;
endpackage

// File: rtl/spi_byte_shifter.sv
// Mode-0 SPI byte engine: shifts one byte out MSB first on MOSI (changing
// after falling edges) and samples MISO on rising edges.
// Assumes: DIV >= 1 clock cycles per SCLK half period; start is only
// honoured while idle; chip select is handled by the caller.
module spi_byte_shifter #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       byte_done,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int CNT_W = (DIV < 2) ? 1 : $clog2(DIV);

    logic             active_q;
    logic [CNT_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [7:0]       sh_q;
    logic [7:0]       rx_q;
    logic             sclk_q;
    logic             done_q;

    // Half-period timing, edge generation, shift and sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            div_q    <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
            rx_q     <= '0;
            sclk_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (start) begin
                    active_q <= 1'b1;
                    sh_q     <= tx_byte;
                    bit_q    <= '0;
                    div_q    <= '0;
                    sclk_q   <= 1'b0;
                end
            end else if (div_q == CNT_W'(DIV - 1)) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    sh_q   <= {sh_q[6:0], 1'b0};
                    bit_q  <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end
                end
            end else begin
                div_q <= div_q + CNT_W'(1);
            end
        end
    end

    assign sclk      = sclk_q;
    assign mosi      = sh_q[7];
    assign rx_byte   = rx_q;
    assign byte_done = done_q;
endmodule

// File: rtl/poll_pacer.sv
// Interval timer between status polls: after an arm pulse it emits a
// one-cycle expiry pulse TICKS cycles later.
// Assumes: TICKS >= 1; a new arm restarts the interval.
module poll_pacer #(
    parameter int TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int T_W = $clog2(TICKS + 1);

    logic [T_W-1:0] cnt_q;
    logic           run_q;
    logic           exp_q;

    // Count down the armed interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (arm) begin
                cnt_q <= T_W'(TICKS - 1);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (cnt_q == '0) begin
                    run_q <= 1'b0;
                    exp_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - T_W'(1);
                end
            end
        end
    end

    assign expired = exp_q;
endmodule

// File: rtl/spi_eeprom_seq.sv
// SPI EEPROM request sequencer. Splits a host request into pieces of at
// most CHUNK bytes. Each write piece gets a write-enable frame, the write
// frame and paced status polling with a timeout. Each read piece gets a
// read frame whose payload bytes are stored to the host buffer.
// Assumes: buf_wdata is valid combinationally for buf_idx; requests are
// only taken while busy is low; CLK_HZ >= 1000 for a 1 ms poll spacing.
module spi_eeprom_seq
    import spi_eeprom_seq_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int SCLK_DIV  = 4,
    parameter int MAX_POLLS = 1000,
    parameter int CHUNK     = 16,
    parameter int LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [15:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [LEN_W-1:0] buf_idx,
    input  logic [7:0]       buf_wdata,
    output logic             buf_we,
    output logic [7:0]       buf_rdata,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n
);
    localparam int POS_W = $clog2(CHUNK + HDR_BYTES + 1);
    localparam int CL_W  = $clog2(CHUNK + 1);
    localparam int ATT_W = $clog2(MAX_POLLS + 1);
    localparam int TICKS = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;

    seq_state_t        state_q, gap_next_q;
    logic [15:0]       addr_q;
    logic [LEN_W-1:0]  rem_q, base_q;
    logic [CL_W-1:0]   chunk_q;
    logic [POS_W-1:0]  pos_q;
    logic              sent_q, launch_q, write_q;
    logic [7:0]        tx_q;
    logic [ATT_W-1:0]  att_q;
    logic              pace_arm_q, done_q, err_q;

    logic              eng_done, pace_exp;
    logic [7:0]        eng_rx;
    logic [POS_W-1:0]  frame_len;
    logic [7:0]        tx_mux;
    logic              in_frame, last_byte, data_pos;
    logic [LEN_W-1:0]  byte_off;

    // Frame length of the state currently on the wire.
    always_comb begin
        case (state_q)
            S_WREN:          frame_len = POS_W'(1);
            S_POLL:          frame_len = POS_W'(2);
            S_WRITE, S_READ: frame_len = POS_W'(HDR_BYTES) + POS_W'(chunk_q);
            default:         frame_len = POS_W'(1);
        endcase
    end

    assign in_frame  = (state_q == S_WREN) || (state_q == S_WRITE) ||
                       (state_q == S_POLL) || (state_q == S_READ);
    assign last_byte = (pos_q == frame_len - POS_W'(1));
    assign data_pos  = (pos_q >= POS_W'(HDR_BYTES));
    assign byte_off  = LEN_W'(pos_q) - LEN_W'(HDR_BYTES);

    // Byte to transmit at the current frame position.
    always_comb begin
        tx_mux = 8'h00;
        case (state_q)
            S_WREN: tx_mux = OP_WREN;
            S_POLL: tx_mux = (pos_q == '0) ? OP_STAT : 8'h00;
            S_WRITE, S_READ: begin
                if (pos_q == POS_W'(0))
                    tx_mux = (state_q == S_WRITE) ? OP_WRITE : OP_READ;
                else if (pos_q == POS_W'(1))
                    tx_mux = addr_q[15:8];
                else if (pos_q == POS_W'(2))
                    tx_mux = addr_q[7:0];
                else
                    tx_mux = (state_q == S_WRITE) ? buf_wdata : 8'h00;
            end
            default: tx_mux = 8'h00;
        endcase
    end

    // Request sequencing: pieces, frames, polling and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            gap_next_q <= S_IDLE;
            addr_q     <= '0;
            rem_q      <= '0;
            base_q     <= '0;
            chunk_q    <= '0;
            pos_q      <= '0;
            sent_q     <= 1'b0;
            launch_q   <= 1'b0;
            write_q    <= 1'b0;
            tx_q       <= '0;
            att_q      <= '0;
            pace_arm_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            launch_q   <= 1'b0;
            pace_arm_q <= 1'b0;
            done_q     <= 1'b0;
            if (in_frame && !sent_q) begin
                launch_q <= 1'b1;
                tx_q     <= tx_mux;
                sent_q   <= 1'b1;
            end
            if (in_frame && eng_done) begin
                sent_q <= 1'b0;
                pos_q  <= last_byte ? '0 : pos_q + POS_W'(1);
            end
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        err_q   <= 1'b0;
                        addr_q  <= req_addr;
                        rem_q   <= req_len;
                        base_q  <= '0;
                        write_q <= req_write;
                        pos_q   <= '0;
                        sent_q  <= 1'b0;
                        if (req_len == '0) done_q  <= 1'b1;
                        else               state_q <= S_CHUNK;
                    end
                end
                S_CHUNK: begin
                    chunk_q <= (rem_q > LEN_W'(CHUNK)) ? CL_W'(CHUNK) : CL_W'(rem_q);
                    state_q <= write_q ? S_WREN : S_READ;
                end
                S_WREN: if (eng_done) begin
                    state_q    <= S_GAP;
                    gap_next_q <= S_WRITE;
                end
                S_GAP: state_q <= gap_next_q;
                S_WRITE: if (eng_done && last_byte) begin
                    state_q    <= S_GAP;
                    gap_next_q <= S_POLL;
                    att_q      <= '0;
                end
                S_POLL: if (eng_done && last_byte) begin
                    if (!eng_rx[0]) begin
                        state_q <= S_NEXT;
                    end else if (att_q == ATT_W'(MAX_POLLS - 1)) begin
                        err_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        att_q      <= att_q + ATT_W'(1);
                        pace_arm_q <= 1'b1;
                        state_q    <= S_WAIT;
                    end
                end
                S_WAIT: if (pace_exp) state_q <= S_POLL;
                S_READ: if (eng_done && last_byte) state_q <= S_NEXT;
                S_NEXT: begin
                    addr_q <= addr_q + 16'(chunk_q);
                    base_q <= base_q + LEN_W'(chunk_q);
                    rem_q  <= rem_q - LEN_W'(chunk_q);
                    if (rem_q == LEN_W'(chunk_q)) begin
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        state_q <= S_CHUNK;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    spi_byte_shifter #(.DIV(SCLK_DIV)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (launch_q),
        .tx_byte   (tx_q),
        .rx_byte   (eng_rx),
        .byte_done (eng_done),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .miso      (spi_miso)
    );

    poll_pacer #(.TICKS(TICKS)) u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (pace_arm_q),
        .expired (pace_exp)
    );

    assign busy      = (state_q != S_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign spi_cs_n  = !in_frame;
    assign buf_idx   = data_pos ? base_q + byte_off : base_q;
    assign buf_we    = eng_done && (state_q == S_READ) && data_pos;
    assign buf_rdata = eng_rx;
endmodule

// File: rtl/spi_eeprom_seq_chk.sv
// Port-level protocol checker for spi_eeprom_seq, bound to every instance.
module spi_eeprom_seq_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [LEN_W-1:0] req_len,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             buf_we,
    input logic             spi_sclk,
    input logic             spi_cs_n
);
    p_sclk_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_cs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_len == '0) |=> (done && spi_cs_n && !busy));

    p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(req_valid && !busy));

    p_we_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (busy && !spi_cs_n));
endmodule

bind spi_eeprom_seq spi_eeprom_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_len   (req_len),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .buf_we    (buf_we),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n)
);

// File: tb/tb_spi_eeprom_seq.sv
module tb_spi_eeprom_seq;
    localparam int TB_HZ = 20000;
    localparam int TICKS = TB_HZ / 1000;
    localparam int MAXP  = 6;
    localparam int CH    = 16;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_len = '0;
    logic        busy, done, err, buf_we, spi_sclk, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;
    logic [15:0] buf_idx;
    logic [7:0]  buf_wdata, buf_rdata;

    int errors = 0, checks = 0, cyc = 0;

    logic [7:0] wbuf [0:63];
    logic [7:0] rbuf [0:63];
    logic [7:0] dev_mem [0:1023];
    logic [7:0] ref_mem [0:1023];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_eeprom_seq #(.CLK_HZ(TB_HZ), .SCLK_DIV(2), .MAX_POLLS(MAXP),
                     .CHUNK(CH), .LEN_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
        .err(err), .buf_idx(buf_idx), .buf_wdata(buf_wdata), .buf_we(buf_we),
        .buf_rdata(buf_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

    assign buf_wdata = wbuf[buf_idx[5:0]];
    always @(posedge clk) if (buf_we) rbuf[buf_idx[5:0]] <= buf_rdata;

    // EEPROM model with frame log
    int bitc = 0, bytec = 0, fcnt = 0, busy_cnt = 0, busy_set = 0;
    logic [7:0]  in_sh = 0, out_sh = 0, nxt = 0, cmd = 0;
    logic [15:0] adr = 0, cur = 0;
    bit load_next = 0, wel = 0;
    logic [7:0]  f_cmd [0:255];
    int          f_len [0:255];
    logic [15:0] f_adr [0:255];
    int          f_t0 [0:255];
    int          f_t1 [0:255];

    always @(negedge spi_cs_n) begin
        bitc = 0; bytec = 0; out_sh = 0; spi_miso = 0; load_next = 0;
        f_t0[fcnt[7:0]] = cyc;
    end
    always @(posedge spi_sclk) if (!spi_cs_n) begin
        in_sh = {in_sh[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            bitc = 0; nxt = 8'h00;
            if (bytec == 0) begin
                cmd = in_sh;
                if (in_sh == 8'h06) wel = 1;
                if (in_sh == 8'h05) nxt = {7'd0, busy_cnt != 0};
            end else if (bytec == 1) adr[15:8] = in_sh;
            else if (bytec == 2) begin
                adr[7:0] = in_sh; cur = adr;
                if (cmd == 8'h03) begin nxt = dev_mem[cur[9:0]]; cur++; end
            end else begin
                if (cmd == 8'h02 && wel) begin dev_mem[cur[9:0]] = in_sh; cur++; end
                else if (cmd == 8'h03) begin nxt = dev_mem[cur[9:0]]; cur++; end
            end
            bytec++; load_next = 1;
        end
    end
    always @(negedge spi_sclk) if (!spi_cs_n) begin
        if (load_next) begin spi_miso = nxt[7]; out_sh = {nxt[6:0], 1'b0}; load_next = 0; end
        else begin spi_miso = out_sh[7]; out_sh = {out_sh[6:0], 1'b0}; end
    end
    always @(posedge spi_cs_n) if (bytec > 0) begin
        f_cmd[fcnt[7:0]] = cmd; f_len[fcnt[7:0]] = bytec;
        f_adr[fcnt[7:0]] = adr; f_t1[fcnt[7:0]] = cyc;
        fcnt++;
        if (cmd == 8'h02 && wel) begin wel = 0; busy_cnt = busy_set; end
        else if (cmd == 8'h05 && busy_cnt > 0) busy_cnt--;
        bytec = 0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    bit got_done, err_at_done;
    task automatic run_req(input bit wr, input logic [15:0] a, input int n);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_len = 16'(n);
        @(negedge clk);
        req_valid = 0;
        got_done = 0;
        for (int i = 0; i < 20000; i++) begin
            if (done) begin got_done = 1; err_at_done = err; break; end
            @(negedge clk);
        end
    endtask

    // wr, addr, len, busy replies, seed
    localparam logic [48:0] VECS [0:6] = '{
        {1'b1, 16'h0010, 8'd5,  8'd2, 8'h11, 8'd0},
        {1'b0, 16'h0010, 8'd5,  8'd0, 8'h00, 8'd0},
        {1'b1, 16'h0100, 8'd20, 8'd0, 8'h40, 8'd0},
        {1'b0, 16'h0100, 8'd20, 8'd0, 8'h00, 8'd0},
        {1'b1, 16'h03E0, 8'd16, 8'd1, 8'h80, 8'd0},
        {1'b0, 16'h03DF, 8'd18, 8'd0, 8'h00, 8'd0},
        {1'b1, 16'h0200, 8'd35, 8'd1, 8'hA5, 8'd0}
    };

    initial begin
        for (int i = 0; i < 1024; i++) begin dev_mem[i] = 8'h00; ref_mem[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        chk(spi_cs_n == 1 && spi_sclk == 0, "R11 cs/sclk", {spi_cs_n, spi_sclk}, 2);
        chk(!busy && !done && !err, "R11 busy/done/err", {busy, done, err}, 0);

        for (int v = 0; v < 7; v++) begin
            automatic bit wr = VECS[v][48];
            automatic logic [15:0] a = VECS[v][47:32];
            automatic int n = int'(VECS[v][31:24]);
            automatic int bz = int'(VECS[v][23:16]);
            automatic logic [7:0] seed = VECS[v][15:8];
            automatic int f = fcnt;
            automatic int nch = (n + CH - 1) / CH;
            automatic int bad = 0;
            for (int i = 0; i < 64; i++) begin
                wbuf[i] = seed + 8'(i * 7); rbuf[i] = 8'hEE;
            end
            busy_set = bz;
            run_req(wr, a, n);
            chk(got_done && !err_at_done, "R8 done without error", {got_done, err_at_done}, 2);
            @(negedge clk);
            chk(!done, "R8 done one cycle", done, 0);
            for (int c = 0; c < nch; c++) begin
                automatic int cl = (n - c * CH > CH) ? CH : n - c * CH;
                automatic logic [15:0] ca = a + 16'(c * CH);
                if (wr) begin
                    chk(f_cmd[f[7:0]] == 8'h06 && f_len[f[7:0]] == 1, "R3 write-enable frame",
                        f_cmd[f[7:0]], 6);
                    chk(f_cmd[8'(f+1)] == 8'h02 && f_adr[8'(f+1)] == ca, "R1 write opcode/address",
                        f_adr[8'(f+1)], ca);
                    chk(f_len[8'(f+1)] == 3 + cl, "R2 write frame length", f_len[8'(f+1)], 3 + cl);
                    f += 2;
                    bad = 0;
                    for (int p = 0; p <= bz; p++) begin
                        if (f_cmd[8'(f+p)] != 8'h05 || f_len[8'(f+p)] != 2) bad++;
                        if (p > 0 && f_t0[8'(f+p)] - f_t1[8'(f+p-1)] < TICKS) begin
                            errors++; checks++;
                            $display("FAIL R5 poll spacing: actual=%0d expected>=%0d",
                                     f_t0[8'(f+p)] - f_t1[8'(f+p-1)], TICKS);
                        end
                    end
                    chk(bad == 0, "R4 status frames", bad, 0);
                    f += bz + 1;
                    for (int i = 0; i < cl; i++) ref_mem[10'(ca + 16'(i))] = wbuf[c * CH + i];
                end else begin
                    chk(f_cmd[f[7:0]] == 8'h03 && f_adr[f[7:0]] == ca, "R1 read opcode/address",
                        f_adr[f[7:0]], ca);
                    chk(f_len[f[7:0]] == 3 + cl, "R2 read frame length", f_len[f[7:0]], 3 + cl);
                    f += 1;
                end
            end
            chk(fcnt == f, "R4 frame count", fcnt, f);
            if (!wr) begin
                bad = 0;
                for (int i = 0; i < n; i++)
                    if (rbuf[i] != ref_mem[10'(a + 16'(i))]) bad++;
                chk(bad == 0, "R7 read data", bad, 0);
            end
        end

        // R10: zero length
        begin
            automatic int f = fcnt;
            @(negedge clk);
            req_valid = 1; req_write = 1; req_len = 0;
            @(negedge clk);
            req_valid = 0;
            chk(done == 1 && spi_cs_n == 1, "R10 immediate done", {done, spi_cs_n}, 3);
            repeat (20) @(negedge clk);
            chk(fcnt == f, "R10 no frame", fcnt, f);
        end

        // R6: timeout, R9: error held then cleared
        begin
            automatic int f = fcnt;
            automatic int polls = 0;
            busy_set = 200;
            run_req(1, 16'h0300, 3);
            chk(got_done && err_at_done, "R6 timeout error", {got_done, err_at_done}, 3);
            for (int i = f; i < fcnt; i++) if (f_cmd[i[7:0]] == 8'h05) polls++;
            chk(polls == MAXP, "R6 poll count", polls, MAXP);
            repeat (200) @(negedge clk);
            chk(err == 1 && fcnt == f + 2 + MAXP, "R9 error held, no frames", err, 1);
            busy_cnt = 0; busy_set = 0;
            @(negedge clk);
            req_valid = 1; req_write = 0; req_addr = 16'h0010; req_len = 2;
            @(negedge clk);
            req_valid = 0;
            chk(err == 0 && busy == 1, "R9 error cleared on start", {err, busy}, 1);
            for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
            chk(rbuf[0] == ref_mem[16] && rbuf[1] == ref_mem[17], "R7 short read", rbuf[1], ref_mem[17]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule